// File: doc/BRIEF.md
# Sequential Multiply and Divide Unit

This unit sits beside a 16-bit processor datapath and performs two arithmetic operations over several clock cycles: multiplying two 16-bit words into a 32-bit result, and dividing a 32-bit word by a 16-bit word. Both operations can be signed or unsigned. The result lands in a pair of dedicated 16-bit result registers, one for the upper word and one for the lower word. These registers are visible on output ports and can be written directly by the processor.

A single-cycle start strobe launches an operation. It carries a 2-bit operation code and two operands. For a divide, the 32-bit dividend is taken from the current contents of the result register pair, so software first writes that pair and then issues the divide. A busy flag covers the whole run. A one-cycle done pulse ends it after a fixed latency that depends only on the operation. A zero divisor is reported through an error flag, and it does not change the latency.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, res_hi, res_lo, busy, done and div_zero are all 0.
- R2: Operation code 2'b00 multiplies unsigned and 2'b01 multiplies signed (two's complement). res_hi receives product bits 31:16 and res_lo receives bits 15:0.
- R3: A multiply accepted at clock edge k raises busy from edge k and raises done for exactly the one cycle after edge k+5.
- R4: Operation code 2'b10 divides unsigned and 2'b11 divides signed. The dividend is {res_hi,res_lo} at the accepting edge and the divisor is opb. The quotient is truncated toward zero and its low 16 bits go to res_lo. The remainder, with the dividend's sign, goes to res_hi.
- R5: A divide accepted at edge k raises done for exactly the one cycle after edge k+10.
- R6: A divide by zero sets div_zero to 1 with done, keeps the latency of R5 and leaves res_hi and res_lo unchanged. Any operation that completes without a zero divisor returns div_zero to 0.
- R7: A start while busy is 1 is ignored. The running operation finishes with its own operands, and no extra done follows.
- R8: When busy is 0, wr_hi and wr_lo load wr_data into res_hi and res_lo respectively on the next edge. While busy is 1 these writes are ignored.
- R9: done is never high for two cycles in a row, and busy is 0 whenever done is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch strobe, accepted when busy is 0 |
| op | input | 2 | Bit 1: divide; bit 0: signed |
| opa | input | 16 | Multiplicand (ignored for divide) |
| opb | input | 16 | Multiplier or divisor |
| wr_hi | input | 1 | Write wr_data to upper result word |
| wr_lo | input | 1 | Write wr_data to lower result word |
| wr_data | input | 16 | Processor write data |
| res_hi | output | 16 | Upper result word (remainder after divide) |
| res_lo | output | 16 | Lower result word (quotient after divide) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| div_zero | output | 1 | Last completed divide had a zero divisor |

## Verification
The assertions rely on start, op and the operands being valid on every edge, and on reset being held long enough to clear the control registers. They place no limits on when start or the write strobes arrive. The stimulus changes inputs only on falling edges and holds each start for exactly one cycle. It deliberately pulses start and the write strobes during a run, so the properties covering ignored requests are exercised and not left vacuous. Signed corner operands such as the most negative dividend divided by minus one stay within the truncated-quotient rule of R4.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [1:0] {
    OP_MULU = 2'b00,
    OP_MULS = 2'b01,
    OP_DIVU = 2'b10,
    OP_DIVS = 2'b11
  } mdu_op_e;

  localparam int OP_SIGNED_BIT = 0;
  localparam int OP_DIV_BIT    = 1;
endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl #(
  parameter int W          = 16,
  parameter int R          = 4,
  parameter int MUL_CYCLES = 5,
  parameter int DIV_CYCLES = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic op_div,
  input  logic op_signed,
  input  logic opb_zero,
  output logic busy,
  output logic done,
  output logic accept,
  output logic step_en,
  output logic fin,
  output logic run_div,
  output logic run_signed,
  output logic run_zero
);
  localparam int MUL_STEPS = W / R;
  localparam int DIV_STEPS = 2 * W / R;
  localparam int CW        = $clog2(DIV_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] steps_lim;
  logic [CW-1:0] last_cnt;

  assign accept = start && !busy;

  always_comb begin
    steps_lim = run_div ? CW'(DIV_STEPS)    : CW'(MUL_STEPS);
    last_cnt  = run_div ? CW'(DIV_CYCLES-1) : CW'(MUL_CYCLES-1);
  end

  assign step_en = busy && (cnt < steps_lim);
  assign fin     = busy && (cnt == last_cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      cnt        <= '0;
      run_div    <= 1'b0;
      run_signed <= 1'b0;
      run_zero   <= 1'b0;
    end else begin
      done <= fin;
      if (accept) begin
        busy       <= 1'b1;
        cnt        <= '0;
        run_div    <= op_div;
        run_signed <= op_signed;
        run_zero   <= opb_zero;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (fin) busy <= 1'b0;
      end
    end
  end

  // shadow run-length counter used only by the latency properties
  logic [CW-1:0] run_len;
  always_ff @(posedge clk) begin
    if (rst)         run_len <= '0;
    else if (accept) run_len <= '0;
    else if (busy)   run_len <= run_len + 1'b1;
  end

  AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst) accept |=> busy); // R3
  AST_MUL_LATENCY: assert property (@(posedge clk) disable iff (rst) (done && !run_div) |-> run_len == CW'(MUL_CYCLES)); // R3
  AST_DIV_LATENCY: assert property (@(posedge clk) disable iff (rst) (done && run_div) |-> run_len == CW'(DIV_CYCLES)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done |-> !busy); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst) busy |=> ($stable(run_div) && $stable(run_signed) && $stable(run_zero))); // R7
endmodule

// File: rtl/mdu_mul.sv
module mdu_mul #(
  parameter int W = 16,
  parameter int R = 4
) (
  input  logic           clk,
  input  logic           load,
  input  logic           step,
  input  logic           is_signed,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] product
);
  logic [2*W-1:0] acc;
  logic [2*W-1:0] mcand;
  logic [W-1:0]   mplier;
  logic           neg;
  logic [W-1:0]   a_mag, b_mag;

  always_comb begin
    a_mag = (is_signed && a[W-1]) ? -a : a;
    b_mag = (is_signed && b[W-1]) ? -b : b;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      acc    <= '0;
      mcand  <= {{W{1'b0}}, a_mag};
      mplier <= b_mag;
      neg    <= is_signed && (a[W-1] ^ b[W-1]);
    end else if (step) begin
      acc    <= acc + mcand * (2*W)'(mplier[R-1:0]);
      mcand  <= mcand << R;
      mplier <= mplier >> R;
    end
  end

  assign product = neg ? -acc : acc;
endmodule

// File: rtl/mdu_div.sv
module mdu_div #(
  parameter int W = 16,
  parameter int R = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic           is_signed,
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]   divisor,
  output logic [W-1:0]   quot,
  output logic [W-1:0]   rem
);
  logic [W-1:0]   pr;
  logic [2*W-1:0] dq;
  logic [W-1:0]   dvs;
  logic           qneg, rneg;
  logic [2*W-1:0] dd_mag;
  logic [W-1:0]   dv_mag;

  logic [W-1:0]   pr_s [R+1];
  logic [2*W-1:0] dq_s [R+1];
  logic [W:0]     t_s  [R];

  always_comb begin
    dd_mag = (is_signed && dividend[2*W-1]) ? -dividend : dividend;
    dv_mag = (is_signed && divisor[W-1])    ? -divisor  : divisor;
  end

  // R restoring subtract stages per clock
  always_comb begin
    pr_s[0] = pr;
    dq_s[0] = dq;
    for (int i = 0; i < R; i++) begin
      t_s[i] = {pr_s[i], dq_s[i][2*W-1]};
      if (t_s[i] >= {1'b0, dvs}) begin
        pr_s[i+1] = W'(t_s[i] - {1'b0, dvs});
        dq_s[i+1] = {dq_s[i][2*W-2:0], 1'b1};
      end else begin
        pr_s[i+1] = t_s[i][W-1:0];
        dq_s[i+1] = {dq_s[i][2*W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      pr   <= '0;
      dq   <= dd_mag;
      dvs  <= dv_mag;
      qneg <= is_signed && (dividend[2*W-1] ^ divisor[W-1]);
      rneg <= is_signed && dividend[2*W-1];
    end else if (step) begin
      pr <= pr_s[R];
      dq <= dq_s[R];
    end
  end

  assign quot = qneg ? -dq[W-1:0] : dq[W-1:0];
  assign rem  = rneg ? -pr : pr;

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (rst) (step && dvs != '0) |=> pr < dvs); // R4
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int W          = 16,
  parameter int R          = 4,
  parameter int MUL_CYCLES = 5,
  parameter int DIV_CYCLES = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         wr_hi,
  input  logic         wr_lo,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo,
  output logic         busy,
  output logic         done,
  output logic         div_zero
);
  logic accept, step_en, fin, run_div, run_signed, run_zero;
  logic op_div, op_signed, opb_zero;
  logic [2*W-1:0] product;
  logic [W-1:0]   quot, rem;

  assign op_div    = op[mdu_pkg::OP_DIV_BIT];
  assign op_signed = op[mdu_pkg::OP_SIGNED_BIT];
  assign opb_zero  = op_div && (opb == '0);

  mdu_ctrl #(.W(W), .R(R), .MUL_CYCLES(MUL_CYCLES), .DIV_CYCLES(DIV_CYCLES)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .op_div(op_div), .op_signed(op_signed),
    .opb_zero(opb_zero), .busy(busy), .done(done), .accept(accept), .step_en(step_en),
    .fin(fin), .run_div(run_div), .run_signed(run_signed), .run_zero(run_zero)
  );

  mdu_mul #(.W(W), .R(R)) u_mul (
    .clk(clk), .load(accept), .step(step_en && !run_div), .is_signed(op_signed),
    .a(opa), .b(opb), .product(product)
  );

  mdu_div #(.W(W), .R(R)) u_div (
    .clk(clk), .rst(rst), .load(accept), .step(step_en && run_div), .is_signed(op_signed),
    .dividend({res_hi, res_lo}), .divisor(opb), .quot(quot), .rem(rem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_hi   <= '0;
      res_lo   <= '0;
      div_zero <= 1'b0;
    end else if (fin) begin
      div_zero <= run_div && run_zero;
      if (!run_div) begin
        res_hi <= product[2*W-1:W];
        res_lo <= product[W-1:0];
      end else if (!run_zero) begin
        res_hi <= rem;
        res_lo <= quot;
      end
    end else if (!busy) begin
      if (wr_hi) res_hi <= wr_data;
      if (wr_lo) res_lo <= wr_data;
    end
  end

  AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (rst) (busy && !fin) |=> ($stable(res_hi) && $stable(res_lo))); // R8
  AST_DZ_KEEPS_RESULT: assert property (@(posedge clk) disable iff (rst) (fin && run_zero) |=> ($stable(res_hi) && $stable(res_lo) && div_zero)); // R6
  AST_MUL_CLEARS_DZ: assert property (@(posedge clk) disable iff (rst) (fin && !run_div) |=> !div_zero); // R6
endmodule

// File: tb/sim_muldiv_unit.sv
module sim_muldiv_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [15:0] opa = '0, opb = '0, wr_data = '0;
  logic        wr_hi = 1'b0, wr_lo = 1'b0;
  logic [15:0] res_hi, res_lo;
  logic        busy, done, div_zero;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  muldiv_unit u0 (
    .clk(clk), .rst(rst), .start(start), .op(op), .opa(opa), .opb(opb),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data), .res_hi(res_hi), .res_lo(res_lo),
    .busy(busy), .done(done), .div_zero(div_zero)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_mul(input logic [1:0] o, input logic [15:0] a, input logic [15:0] b);
    logic signed [63:0] sa, sb, p;
    sa = o[0] ? {{48{a[15]}}, a} : {48'b0, a};
    sb = o[0] ? {{48{b[15]}}, b} : {48'b0, b};
    p  = sa * sb;
    return p[31:0];
  endfunction

  function automatic logic [31:0] exp_div(input logic [1:0] o, input logic [31:0] d, input logic [15:0] v);
    logic signed [63:0] sd, sv, q, r;
    sd = o[0] ? {{32{d[31]}}, d} : {32'b0, d};
    sv = o[0] ? {{48{v[15]}}, v} : {48'b0, v};
    q  = sd / sv;
    r  = sd % sv;
    return {r[15:0], q[15:0]};
  endfunction

  task automatic cpu_write(input logic [31:0] val);
    @(negedge clk); wr_hi = 1'b1; wr_data = val[31:16];
    @(negedge clk); wr_hi = 1'b0; wr_lo = 1'b1; wr_data = val[15:0];
    @(negedge clk); wr_lo = 1'b0;
  endtask

  // launches one operation, returns cycles from accept edge to done
  task automatic run_op(input logic [1:0] o, input logic [15:0] a, input logic [15:0] b,
                        input string req, output int n);
    bit gap = 0;
    @(negedge clk); start = 1'b1; op = o; opa = a; opb = b;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, req, "busy after accept", {31'b0, busy}, 32'd1);
    n = 0;
    while (!done && n < 40) begin
      @(negedge clk); n++;
      if (!done && !busy) gap = 1;
    end
    check(!gap, req, "busy held until done", {31'b0, gap}, 32'd0);
    check(busy == 1'b0, "R9", "busy low with done", {31'b0, busy}, 32'd0);
    @(negedge clk);
    check(done == 1'b0, "R9", "done single cycle", {31'b0, done}, 32'd0);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check({res_hi, res_lo} == 32'd0, "R1", "result regs at reset", {res_hi, res_lo}, 32'd0);
    check({busy, done, div_zero} == 3'b000, "R1", "flags at reset", {29'b0, busy, done, div_zero}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_mul(input logic [1:0] o, input logic [15:0] a, input logic [15:0] b);
    int n;
    logic [31:0] e;
    e = exp_mul(o, a, b);
    run_op(o, a, b, "R3", n);
    check(n == 5, "R3", "multiply latency", n, 32'd5);
    check({res_hi, res_lo} == e, "R2", "product", {res_hi, res_lo}, e);
    check(div_zero == 1'b0, "R6", "div_zero clear after multiply", {31'b0, div_zero}, 32'd0);
  endtask

  task automatic t_div(input logic [1:0] o, input logic [31:0] d, input logic [15:0] v);
    int n;
    logic [31:0] e;
    cpu_write(d);
    e = exp_div(o, d, v);
    run_op(o, 16'h0000, v, "R5", n);
    check(n == 10, "R5", "divide latency", n, 32'd10);
    check({res_hi, res_lo} == e, "R4", "remainder/quotient", {res_hi, res_lo}, e);
    check(div_zero == 1'b0, "R6", "div_zero clear", {31'b0, div_zero}, 32'd0);
  endtask

  task automatic t_div_zero;
    int n;
    cpu_write(32'h1234_5678);
    run_op(2'b11, 16'h0000, 16'h0000, "R6", n);
    check(n == 10, "R6", "zero-divisor latency", n, 32'd10);
    check(div_zero == 1'b1, "R6", "div_zero set", {31'b0, div_zero}, 32'd1);
    check({res_hi, res_lo} == 32'h1234_5678, "R6", "results untouched", {res_hi, res_lo}, 32'h1234_5678);
    t_mul(2'b00, 16'd3, 16'd4);
  endtask

  task automatic t_start_busy;
    int n;
    logic [31:0] e;
    e = exp_mul(2'b00, 16'd300, 16'd7);
    @(negedge clk); start = 1'b1; op = 2'b00; opa = 16'd300; opb = 16'd7;
    @(negedge clk); start = 1'b1; op = 2'b11; opa = 16'h7777; opb = 16'h0000;
    @(negedge clk); start = 1'b0;
    n = 1;
    while (!done && n < 40) begin @(negedge clk); n++; end
    check(n == 5, "R7", "latency with stray start", n, 32'd5);
    check({res_hi, res_lo} == e, "R7", "first operands kept", {res_hi, res_lo}, e);
    check(div_zero == 1'b0, "R7", "stray zero divisor ignored", {31'b0, div_zero}, 32'd0);
    begin
      bit extra = 0;
      repeat (14) begin @(negedge clk); if (done || busy) extra = 1; end
      check(!extra, "R7", "no second run", {31'b0, extra}, 32'd0);
    end
  endtask

  task automatic t_write_busy;
    logic [31:0] e;
    e = exp_mul(2'b01, 16'hFF00, 16'h0123);
    @(negedge clk); start = 1'b1; op = 2'b01; opa = 16'hFF00; opb = 16'h0123;
    @(negedge clk); start = 1'b0; wr_hi = 1'b1; wr_lo = 1'b1; wr_data = 16'hAAAA;
    repeat (3) @(negedge clk);
    wr_hi = 1'b0; wr_lo = 1'b0;
    while (!done) @(negedge clk);
    check({res_hi, res_lo} == e, "R8", "writes during run ignored", {res_hi, res_lo}, e);
    @(negedge clk); wr_hi = 1'b1; wr_data = 16'h1357;
    @(negedge clk); wr_hi = 1'b0;
    check({res_hi, res_lo} == {16'h1357, e[15:0]}, "R8", "idle upper write", {res_hi, res_lo}, {16'h1357, e[15:0]});
    @(negedge clk); wr_lo = 1'b1; wr_data = 16'h2468;
    @(negedge clk); wr_lo = 1'b0;
    check({res_hi, res_lo} == 32'h1357_2468, "R8", "idle lower write", {res_hi, res_lo}, 32'h1357_2468);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    t_reset();
    t_mul(2'b00, 16'hFFFF, 16'hFFFF);
    t_mul(2'b01, 16'hFFFF, 16'hFFFF);
    t_mul(2'b01, 16'h8000, 16'h8000);
    t_mul(2'b01, 16'h1234, 16'hFFFD);
    t_mul(2'b00, 16'h0000, 16'hABCD);
    t_div(2'b10, 32'h0001_0000, 16'd3);
    t_div(2'b11, 32'hFFFF_FF9C, 16'd7);
    t_div(2'b11, 32'd100, 16'hFFF9);
    t_div(2'b10, 32'hFFFF_FFFF, 16'hFFFF);
    t_div(2'b11, 32'h8000_0000, 16'hFFFF);
    t_div_zero();
    t_start_busy();
    t_write_busy();
    summary();
  end
endmodule